// File: doc/BRIEF.md
# Dual-Output Serial Flash Read Responder

This block is the device side of a serial NOR flash that answers a single command: a fast read that returns data two bits per clock. A host selects the device by pulling chip select low. It then clocks in, most significant bit first on the single input line, an 8-bit command code, a 24-bit byte address and eight dummy bits. All of these are sampled on rising serial clock edges. From the next falling edge on, the block drives stored bytes on two data pins, one bit pair per clock. The address advances after every byte. Streaming continues until chip select goes high, which clears all transaction state.

The serial pins are oversampled by a synchronous system clock. Chip select, serial clock and the input line pass through synchronizer chains of equal depth, so their relative order is kept. Serial clock edges are then recovered as single-cycle strobes. A small byte array stands in for the flash cells and is written through a simple load port. The array is indexed by the low address bits, so the full 23-bit address space aliases onto it.

Top module: `flash_dual_read`

## Requirements
- R1: While `spi_cs_n` is high, or after it rises in the middle of any phase, the block returns to idle and `dq_oe` is 0 within a few system clocks. The next selection starts a fresh header.
- R2: The header consists of 8 command bits, then 24 address bits, then 8 dummy bits. It is shifted in MSB first on `spi_si` and sampled on rising edges of `spi_sck`.
- R3: Only command code 0x3B starts a data phase. After any other code, `dq_oe` stays 0 for the rest of the selection.
- R4: Data output begins on the falling `spi_sck` edge that follows the 40th rising edge. Each byte takes four clocks. On clock k (k = 0..3), `dq1_out` carries bit 7-2k and `dq0_out` carries bit 6-2k. The data pins change only after falling edges.
- R5: After the fourth bit pair of a byte, the read address increases by one. Address 0x7FFFFF is followed by 0x000000, so a read can run on indefinitely.
- R6: Address bit A23, the first address bit received, has no effect on which byte is returned.
- R7: `dq_oe` is 0 throughout the command, address and dummy phases.
- R8: A read may begin at any byte address, with no alignment restriction.
- R9: The idle level of `spi_sck` while deselected (low for mode 0, high for mode 3) has no effect on the data returned.
- R10: A cycle with `ld_en` high writes `ld_data` into the array entry `ld_addr`. A read of address A returns the entry A modulo 2^MEM_AW.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial command, address and dummy input |
| dq0_out | output | 1 | Data pin carrying even-numbered bits |
| dq1_out | output | 1 | Data pin carrying odd-numbered bits |
| dq_oe | output | 1 | Drive enable for both data pins; 0 means high impedance |
| ld_en | input | 1 | Write strobe for the byte array |
| ld_addr | input | MEM_AW | Byte array write index |
| ld_data | input | 8 | Byte array write data |

## Verification
The assertions assume that `spi_sck`, `spi_cs_n` and `spi_si` are each held for well over the synchronizer depth in system clocks. They also assume that `spi_si` never changes at the same moment as a rising serial clock. The bench therefore moves the serial pins only on falling system clock edges and holds each serial half period for six system clocks. It changes the input bit together with the falling serial edge, a full half period before the next rise. Chip select is moved only while the serial clock sits at its idle level, so no spurious edge lands inside a selection. The array is loaded only between transactions.

// File: rtl/flash_dual_read_pkg.sv
package flash_dual_read_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } rd_state_e;

  localparam logic [7:0] OPC_DUAL_READ = 8'h3B;

endpackage

// File: rtl/dfr_pin_sync.sv
module dfr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  output logic rst_sn,
  output logic cs_act,
  output logic si_s,
  output logic sck_rise,
  output logic sck_fall
);

  logic [STAGES-1:0] rst_pipe;
  logic [STAGES-1:0] sck_pipe;
  logic [STAGES-1:0] cs_pipe;
  logic [STAGES-1:0] si_pipe;
  logic              sck_prev;
  logic              sck_s;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= 1'b0;
        else        rst_pipe <= 1'b1;
      end
      always_ff @(posedge clk or negedge rst_sn) begin
        if (!rst_sn) begin
          sck_pipe <= 1'b0;
          cs_pipe  <= 1'b1;
          si_pipe  <= 1'b0;
        end else begin
          sck_pipe <= sck_i;
          cs_pipe  <= cs_n_i;
          si_pipe  <= si_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[STAGES-2:0], 1'b1};
      end
      always_ff @(posedge clk or negedge rst_sn) begin
        if (!rst_sn) begin
          sck_pipe <= '0;
          cs_pipe  <= '1;
          si_pipe  <= '0;
        end else begin
          sck_pipe <= {sck_pipe[STAGES-2:0], sck_i};
          cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n_i};
          si_pipe  <= {si_pipe[STAGES-2:0], si_i};
        end
      end
    end
  endgenerate

  assign rst_sn = rst_pipe[STAGES-1];
  assign sck_s  = sck_pipe[STAGES-1];
  assign si_s   = si_pipe[STAGES-1];
  assign cs_act = ~cs_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) sck_prev <= 1'b0;
    else         sck_prev <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_prev;
  assign sck_fall = ~sck_s & sck_prev;

endmodule

// File: rtl/dfr_cmd_fsm.sv
module dfr_cmd_fsm
  import flash_dual_read_pkg::*;
#(
  parameter int OPC_BITS   = 8,
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_BITS = 8,
  localparam int HDR_BITS  = OPC_BITS + ADDR_BITS + DUMMY_BITS,
  localparam int CNT_W     = $clog2(HDR_BITS + 1),
  localparam int RA_W      = ADDR_BITS - 1
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             cs_act,
  input  logic             sck_rise,
  input  logic             si_s,
  output rd_state_e        st_q,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [RA_W-1:0]  hdr_addr,
  output logic             go_data
);

  localparam int SH_W = RA_W - 1;
  localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(OPC_BITS - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(OPC_BITS + ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);

  rd_state_e        st_d;
  logic [CNT_W-1:0] cnt_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic [RA_W-1:0]  addr_d;
  logic             sh_en, cnt_en, addr_en;
  logic [OPC_BITS-1:0] opc_now;
  logic [RA_W-1:0]     addr_now;

  assign opc_now  = {sh_q[OPC_BITS-2:0], si_s};
  assign addr_now = {sh_q, si_s};

  always_comb begin
    st_d    = st_q;
    cnt_d   = bit_cnt;
    sh_d    = sh_q;
    addr_d  = hdr_addr;
    sh_en   = 1'b0;
    cnt_en  = 1'b0;
    addr_en = 1'b0;
    go_data = 1'b0;
    if (!cs_act) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      cnt_en = (bit_cnt != '0);
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d   = ST_HDR;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
        ST_HDR: begin
          if (sck_rise) begin
            sh_d   = addr_now[SH_W-1:0];
            sh_en  = 1'b1;
            cnt_d  = bit_cnt + 1'b1;
            cnt_en = 1'b1;
            if (bit_cnt == OPC_LAST && opc_now != OPC_DUAL_READ) begin
              st_d = ST_SKIP;
            end
            if (bit_cnt == ADDR_LAST) begin
              addr_d  = addr_now;
              addr_en = 1'b1;
            end
            if (bit_cnt == HDR_LAST) begin
              st_d    = ST_DATA;
              go_data = 1'b1;
            end
          end
        end
        ST_DATA: st_d = ST_DATA;
        ST_SKIP: st_d = ST_SKIP;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q     <= ST_IDLE;
      bit_cnt  <= '0;
      sh_q     <= '0;
      hdr_addr <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en)  bit_cnt  <= cnt_d;
      if (sh_en)   sh_q     <= sh_d;
      if (addr_en) hdr_addr <= addr_d;
    end
  end

endmodule

// File: rtl/dfr_byte_store.sv
module dfr_byte_store #(
  parameter int MEM_AW = 8,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] wr_idx,
  input  logic [7:0]        wr_byte,
  input  logic [MEM_AW-1:0] rd_idx,
  output logic [7:0]        rd_byte
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_byte;
  end

  assign rd_byte = cells[rd_idx];

endmodule

// File: rtl/dfr_dual_shifter.sv
module dfr_dual_shifter
  import flash_dual_read_pkg::*;
#(
  parameter int RA_W   = 23,
  parameter int MEM_AW = 8,
  localparam int PAIRS = 4,
  localparam int PI_W  = $clog2(PAIRS)
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              cs_act,
  input  rd_state_e         st_q,
  input  logic              go_data,
  input  logic              sck_fall,
  input  logic [RA_W-1:0]   hdr_addr,
  input  logic [7:0]        cur_byte,
  output logic [MEM_AW-1:0] rd_idx,
  output logic [RA_W-1:0]   rd_addr,
  output logic              dq0_q,
  output logic              dq1_q,
  output logic              oe_q
);

  localparam logic [PI_W-1:0] PAIR_LAST = PI_W'(PAIRS - 1);

  logic [RA_W-1:0] addr_d;
  logic [PI_W-1:0] pair_q, pair_d;
  logic            dq0_d, dq1_d, oe_d;
  logic            addr_en, pair_en, dq_en, oe_en;
  logic [2:0]      hi_pos;

  assign hi_pos = 3'(2 * (PAIRS - 1 - int'(pair_q)) + 1);
  assign rd_idx = rd_addr[MEM_AW-1:0];

  always_comb begin
    addr_d  = rd_addr;
    pair_d  = pair_q;
    dq0_d   = dq0_q;
    dq1_d   = dq1_q;
    oe_d    = oe_q;
    addr_en = 1'b0;
    pair_en = 1'b0;
    dq_en   = 1'b0;
    oe_en   = 1'b0;
    if (!cs_act) begin
      oe_d    = 1'b0;
      oe_en   = 1'b1;
      pair_d  = '0;
      pair_en = 1'b1;
    end else if (go_data) begin
      addr_d  = hdr_addr;
      addr_en = 1'b1;
      pair_d  = '0;
      pair_en = 1'b1;
    end else if (st_q == ST_DATA && sck_fall) begin
      dq1_d   = cur_byte[hi_pos];
      dq0_d   = cur_byte[hi_pos - 3'd1];
      dq_en   = 1'b1;
      oe_d    = 1'b1;
      oe_en   = 1'b1;
      pair_en = 1'b1;
      if (pair_q == PAIR_LAST) begin
        pair_d  = '0;
        addr_d  = rd_addr + 1'b1;
        addr_en = 1'b1;
      end else begin
        pair_d = pair_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rd_addr <= '0;
      pair_q  <= '0;
      dq0_q   <= 1'b0;
      dq1_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (addr_en) rd_addr <= addr_d;
      if (pair_en) pair_q  <= pair_d;
      if (dq_en) begin
        dq0_q <= dq0_d;
        dq1_q <= dq1_d;
      end
      if (oe_en) oe_q <= oe_d;
    end
  end

endmodule

// File: rtl/flash_dual_read.sv
module flash_dual_read
  import flash_dual_read_pkg::*;
#(
  parameter int MEM_AW      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OPC_BITS    = 8,
  parameter int ADDR_BITS   = 24,
  parameter int DUMMY_BITS  = 8,
  localparam int RA_W       = ADDR_BITS - 1,
  localparam int CNT_W      = $clog2(OPC_BITS + ADDR_BITS + DUMMY_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  output logic              dq0_out,
  output logic              dq1_out,
  output logic              dq_oe,
  input  logic              ld_en,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [7:0]        ld_data
);

  logic              rst_sn, cs_act, si_s, sck_rise, sck_fall;
  rd_state_e         st_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [RA_W-1:0]   hdr_addr, rd_addr;
  logic              go_data;
  logic [MEM_AW-1:0] rd_idx;
  logic [7:0]        cur_byte;

  dfr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_i    (spi_sck),
    .cs_n_i   (spi_cs_n),
    .si_i     (spi_si),
    .rst_sn   (rst_sn),
    .cs_act   (cs_act),
    .si_s     (si_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  dfr_cmd_fsm #(
    .OPC_BITS   (OPC_BITS),
    .ADDR_BITS  (ADDR_BITS),
    .DUMMY_BITS (DUMMY_BITS)
  ) u_fsm (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .cs_act   (cs_act),
    .sck_rise (sck_rise),
    .si_s     (si_s),
    .st_q     (st_q),
    .bit_cnt  (bit_cnt),
    .hdr_addr (hdr_addr),
    .go_data  (go_data)
  );

  dfr_byte_store #(.MEM_AW(MEM_AW)) u_store (
    .clk     (clk),
    .wr_en   (ld_en),
    .wr_idx  (ld_addr),
    .wr_byte (ld_data),
    .rd_idx  (rd_idx),
    .rd_byte (cur_byte)
  );

  dfr_dual_shifter #(
    .RA_W   (RA_W),
    .MEM_AW (MEM_AW)
  ) u_shift (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .cs_act   (cs_act),
    .st_q     (st_q),
    .go_data  (go_data),
    .sck_fall (sck_fall),
    .hdr_addr (hdr_addr),
    .cur_byte (cur_byte),
    .rd_idx   (rd_idx),
    .rd_addr  (rd_addr),
    .dq0_q    (dq0_out),
    .dq1_q    (dq1_out),
    .oe_q     (dq_oe)
  );

endmodule

// File: rtl/flash_dual_read_chk.sv
module flash_dual_read_chk
  import flash_dual_read_pkg::*;
#(
  parameter int RA_W     = 23,
  parameter int CNT_W    = 6,
  parameter int HDR_BITS = 40
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             cs_act,
  input logic             sck_fall,
  input rd_state_e        st_q,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [RA_W-1:0]  rd_addr,
  input logic             dq0_out,
  input logic             dq1_out,
  input logic             dq_oe
);

  // R1: deselection returns the sequencer to idle on the next cycle
  a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    !cs_act |=> st_q == ST_IDLE);

  // R1: no drive outside the data phase
  a_r1_quiet_outside_data: assert property (@(posedge clk) disable iff (!rst_sn)
    st_q == ST_IDLE |-> !dq_oe);

  // R2: header bit counter never runs past the header length
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_sn)
    st_q == ST_HDR |-> int'(bit_cnt) < HDR_BITS);

  // R3: rejected command never drives
  a_r3_skip_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    st_q == ST_SKIP |-> !dq_oe);

  // R4: data pins move only after a falling serial clock
  a_r4_change_on_fall: assert property (@(posedge clk) disable iff (!rst_sn)
    (dq_oe && $past(dq_oe) && !$past(sck_fall)) |-> $stable({dq1_out, dq0_out}));

  // R5: address steps by exactly one, wrapping at the top
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_DATA && $past(st_q) == ST_DATA && rd_addr != $past(rd_addr))
      |-> rd_addr == $past(rd_addr) + 1'b1);

  // R7: header phases keep the pins released
  a_r7_hdr_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    st_q == ST_HDR |-> !dq_oe);

endmodule

bind flash_dual_read flash_dual_read_chk #(
  .RA_W     (RA_W),
  .CNT_W    (CNT_W),
  .HDR_BITS (OPC_BITS + ADDR_BITS + DUMMY_BITS)
) u_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .cs_act   (cs_act),
  .sck_fall (sck_fall),
  .st_q     (st_q),
  .bit_cnt  (bit_cnt),
  .rd_addr  (rd_addr),
  .dq0_out  (dq0_out),
  .dq1_out  (dq1_out),
  .dq_oe    (dq_oe)
);

// File: tb/flash_dual_read_tb.sv
module flash_dual_read_tb;

  localparam int MEM_AW = 8;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int HALF   = 6;

  logic clk, rst_n;
  logic spi_sck, spi_cs_n, spi_si;
  logic dq0_out, dq1_out, dq_oe;
  logic ld_en;
  logic [MEM_AW-1:0] ld_addr;
  logic [7:0] ld_data;

  flash_dual_read #(.MEM_AW(MEM_AW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .spi_si   (spi_si),
    .dq0_out  (dq0_out),
    .dq1_out  (dq1_out),
    .dq_oe    (dq_oe),
    .ld_en    (ld_en),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] model [DEPTH];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  event sample_ev;
  bit   mon_en = 1'b0;
  int   npair  = 0;
  logic [7:0] acc = '0;
  bit   oe_ok  = 1'b1;
  bit   hdr_oe_bad = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: assembles bit pairs into bytes and compares with the scoreboard
  always @(sample_ev) begin
    if (mon_en) begin
      if (!dq_oe) oe_ok = 1'b0;
      acc = {acc[5:0], dq1_out, dq0_out};
      npair++;
      if (npair == 4) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected byte", {24'd0, acc}, 32'd0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(oe_ok && acc === e, t, "data byte", {24'd0, acc}, {24'd0, e});
        end
        npair = 0;
        oe_ok = 1'b1;
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hdr_bit(input logic b);
    spi_sck = 1'b0;
    spi_si  = b;
    wait_clk(HALF);
    if (dq_oe) hdr_oe_bad = 1'b1;
    spi_sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic data_pair();
    spi_sck = 1'b0;
    wait_clk(HALF);
    ->sample_ev;
    spi_sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic select(input bit mode3);
    spi_sck = mode3;
    wait_clk(HALF);
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    hdr_oe_bad = 1'b0;
  endtask

  task automatic deselect(input bit mode3);
    if (!mode3) spi_sck = 1'b0;
    else        spi_sck = 1'b1;
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic send_header(input logic [7:0] opc, input logic [23:0] addr);
    for (int i = 7; i >= 0; i--)  hdr_bit(opc[i]);
    for (int i = 23; i >= 0; i--) hdr_bit(addr[i]);
    for (int i = 0; i < 8; i++)   hdr_bit(1'b0);
  endtask

  // Driver: full read, pushing the expected bytes for the monitor
  task automatic do_read(input logic [23:0] addr, input int nbytes,
                         input bit mode3, input string tag);
    int idx;
    idx = int'(addr[MEM_AW-1:0]);
    npair = 0;
    oe_ok = 1'b1;
    for (int k = 0; k < nbytes; k++) begin
      exp_q.push_back(model[(idx + k) % DEPTH]);
      tag_q.push_back(tag);
    end
    select(mode3);
    send_header(8'h3B, addr);
    check(!hdr_oe_bad, "R7", "drive during header", {31'd0, hdr_oe_bad}, 32'd0);
    mon_en = 1'b1;
    for (int k = 0; k < nbytes * 4; k++) data_pair();
    mon_en = 1'b0;
    deselect(mode3);
    check(exp_q.size() == 0, "R4", "bytes left unread", exp_q.size(), 32'd0);
    check(dq_oe == 1'b0, "R1", "oe after deselect", {31'd0, dq_oe}, 32'd0);
  endtask

  task automatic load_byte(input int i, input logic [7:0] v);
    ld_en   = 1'b1;
    ld_addr = MEM_AW'(i);
    ld_data = v;
    model[i] = v;
    wait_clk(1);
    ld_en = 1'b0;
  endtask

  initial begin
    spi_sck  = 1'b0;
    spi_cs_n = 1'b1;
    spi_si   = 1'b0;
    ld_en    = 1'b0;
    ld_addr  = '0;
    ld_data  = '0;
    rst_n    = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check(dq_oe == 1'b0, "R1", "oe after reset", {31'd0, dq_oe}, 32'd0);

    // R10: fill the array
    for (int i = 0; i < DEPTH; i++) load_byte(i, 8'((i * 37 + 8'h5B) ^ (i >> 2)));

    // R2 R4 R5: mode 0, from address zero
    do_read(24'h000000, 6, 1'b0, "R4");
    // R8 R9: unaligned start, mode 3 idle level
    do_read(24'h000123, 5, 1'b1, "R8");
    do_read(24'h000057, 3, 1'b0, "R9");
    // R5: wrap across the top of the address space
    do_read(24'h7FFFFE, 4, 1'b0, "R5");
    // R6: A23 set has no effect
    do_read(24'h8000A7, 3, 1'b1, "R6");

    // R3: foreign command code, pins stay released
    begin
      bit seen;
      seen = 1'b0;
      select(1'b0);
      send_header(8'h0B, 24'h000010);
      for (int k = 0; k < 16; k++) begin
        data_pair();
        if (dq_oe) seen = 1'b1;
      end
      deselect(1'b0);
      check(!seen, "R3", "oe after foreign code", {31'd0, seen}, 32'd0);
    end

    // R1: abort in the middle of a byte, then a clean read
    begin
      select(1'b0);
      send_header(8'h3B, 24'h000020);
      data_pair();
      data_pair();
      check(dq_oe == 1'b1, "R4", "oe during data", {31'd0, dq_oe}, 32'd1);
      spi_cs_n = 1'b1;
      wait_clk(2 * HALF);
      check(dq_oe == 1'b0, "R1", "oe after abort", {31'd0, dq_oe}, 32'd0);
      spi_sck = 1'b0;
      wait_clk(HALF);
    end
    do_read(24'h000040, 2, 1'b0, "R1");

    // R10: rewrite one entry, read it back
    load_byte(16, 8'hA5);
    do_read(24'h000010, 1, 1'b0, "R10");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule